// File: doc/BRIEF.md
# AGC Floating-Point Gain Multiplier and Requantizer

This block sits in the forward path of an automatic gain control loop. It multiplies complex I/Q samples by a gain held in a small log-domain floating-point word: a 4-bit exponent that shifts by a power of two and an 8-bit mantissa that is the fractional part of log2 of the gain. The mantissa selects a fine multiplier 2^(m/256) from a table that is computed at elaboration. The result is a 19-bit scaled sample per lane, which a power detector can use directly.

The scaled sample is then reduced to a runtime-selectable width of 4 to 16 bits by saturating clipping. For each lane the block also exports the clipping residue, which is the scaled value minus the reduced value. A loop that regulates the clipping level rather than the signal level uses this residue. The gain comes either from the loop, through a load strobe, or from a startup value until the loop has supplied its first word.

Top module: `agc_gain_requant`

## Requirements
- R1: For each lane, `scaled` = sat19(floor(x * T(m) * 2^e / 1024)). The gain word carries the exponent e in bits [11:8] and the mantissa m in bits [7:0].
- R2: The fine multiplier is T(m) = round(2^(m/256) * 1024), an unsigned 1.10 value. e=0, m=0 passes x unchanged, and m=128 gives T=1448.
- R3: `scaled` saturates to the 19-bit range -262144 to 262143.
- R4: After reset, `init_gain` sets the gain until the first `gain_load` pulse. After that pulse, `init_gain` has no effect.
- R5: A word loaded with `gain_load` applies to samples whose `in_valid` arrives in later cycles. A sample in the same cycle as the strobe uses the previous gain. I and Q always use the same gain.
- R6: `width_sel` codes 0..7 select output widths 4, 5, 6, 7, 8, 10, 12 and 16 bits. `req_i` and `req_q` are sign-extended to 16 bits and always lie inside the range of the selected width.
- R7: A scaled value above 2^(w-1)-1 gives exactly 2^(w-1)-1. A value below -2^(w-1) gives exactly -2^(w-1). In-range values pass unchanged.
- R8: `err` = `scaled` - `req` as a 19-bit signed value, so it is zero whenever no clipping took place.
- R9: Results appear three rising edges after the edge that takes a sample. `out_valid` is high for exactly one cycle per sample.
- R10: Reset clears every output to zero with `out_valid` low. Between samples, all outputs hold their last value.
- R11: `width_sel` is taken together with each sample, so back-to-back samples in consecutive cycles may each use a different width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample strobe for in_i/in_q/width_sel |
| in_i | input | 16 | Signed in-phase sample |
| in_q | input | 16 | Signed quadrature sample |
| gain_load | input | 1 | Load strobe for gain_word |
| gain_word | input | 12 | Gain from the loop: exponent [11:8], mantissa [7:0] |
| init_gain | input | 12 | Startup gain in the same format |
| width_sel | input | 3 | Output width code |
| out_valid | output | 1 | Result strobe |
| scaled_i | output | 19 | Scaled in-phase value |
| scaled_q | output | 19 | Scaled quadrature value |
| req_i | output | 16 | Clipped in-phase value, sign-extended |
| req_q | output | 16 | Clipped quadrature value, sign-extended |
| err_i | output | 19 | In-phase clipping residue |
| err_q | output | 19 | Quadrature clipping residue |

## Verification
A wrong table entry or exponent shift shows up in `scaled` three edges after the sample enters, and only for the mantissa or exponent values involved. For this reason the stimulus spreads across both fields and includes the exact literal values 1448 and unity. A stale gain register or a wrong hand-over from `init_gain` shows up in the first sample after the strobe, so same-cycle and next-cycle samples are compared against the old and the new gain. A width-select code that is taken from the wrong pipeline stage shows up only when the width changes between adjacent samples, so back-to-back samples with different widths are checked. A fault in the clip limits breaks the relation between `req` and `err` on the same strobe.

// File: rtl/agc_gain_pkg.sv
package agc_gain_pkg;

    localparam int AGC_IN_W     = 16;
    localparam int AGC_EXP_W    = 4;
    localparam int AGC_MANT_W   = 8;
    localparam int AGC_LUT_FRAC = 10;
    localparam int AGC_SCALED_W = 19;
    localparam int AGC_OUT_W    = 16;

    // Output width code, decoded by width_of.
    typedef logic [2:0] wsel_t;

    // Output width selected by a width code (non-uniform set).
    function automatic int width_of(input wsel_t code);
        case (code)
            3'd0:    return 4;
            3'd1:    return 5;
            3'd2:    return 6;
            3'd3:    return 7;
            3'd4:    return 8;
            3'd5:    return 10;
            3'd6:    return 12;
            default: return 16;
        endcase
    endfunction

    // Integer square root, bit by bit, used only while building constants.
    function automatic logic [127:0] fx_isqrt(input logic [127:0] v);
        logic [127:0] rem;
        logic [127:0] res;
        logic [127:0] one;
        rem = v;
        res = '0;
        one = 128'd1 << 126;
        for (int k = 0; k < 64; k++) begin
            if (rem >= res + one) begin
                rem = rem - (res + one);
                res = (res >> 1) + one;
            end else begin
                res = res >> 1;
            end
            one = one >> 2;
        end
        return res;
    endfunction

endpackage

// File: rtl/agc_mant_lut.sv
// Fine gain table: entry m holds round(2^(m/2^MANT_W) * 2^FRAC_W).
// Built at elaboration from repeated square roots of two.
module agc_mant_lut #(
    parameter int MANT_W = agc_gain_pkg::AGC_MANT_W,
    parameter int FRAC_W = agc_gain_pkg::AGC_LUT_FRAC
) (
    input  logic [MANT_W-1:0] mant,
    output logic [FRAC_W:0]   mult
);

    localparam int N  = 1 << MANT_W;
    localparam int EW = FRAC_W + 1;
    localparam int FX = 40;

    function automatic logic [N*EW-1:0] build_table();
        logic [127:0] roots [MANT_W];
        logic [127:0] r;
        logic [127:0] acc;
        logic [N*EW-1:0] t;
        t = '0;
        r = 128'd2 << FX;
        // roots[b] = 2^(2^b / N) in FX-bit fixed point
        for (int k = MANT_W - 1; k >= 0; k--) begin
            r = agc_gain_pkg::fx_isqrt(r << FX);
            roots[k] = r;
        end
        for (int m = 0; m < N; m++) begin
            acc = 128'd1 << FX;
            for (int b = 0; b < MANT_W; b++) begin
                if (m[b]) acc = (acc * roots[b]) >> FX;
            end
            acc = (acc + (128'd1 << (FX - FRAC_W - 1))) >> (FX - FRAC_W);
            t[m*EW +: EW] = acc[EW-1:0];
        end
        return t;
    endfunction

    localparam logic [N*EW-1:0] TABLE = build_table();

    always_comb begin
        mult = TABLE[int'(mant)*EW +: EW];
    end

endmodule

// File: rtl/agc_gain_select.sv
// Holds the loop gain; the startup word is used until the first load.
module agc_gain_select #(
    parameter int GAIN_W = agc_gain_pkg::AGC_EXP_W + agc_gain_pkg::AGC_MANT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [GAIN_W-1:0] word,
    input  logic [GAIN_W-1:0] init_word,
    output logic [GAIN_W-1:0] active
);

    typedef struct packed {
        logic              loaded;
        logic [GAIN_W-1:0] held;
    } sel_st_t;

    sel_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.loaded = 1'b1;
            st_d.held   = word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = st_q.loaded ? st_q.held : init_word;

endmodule

// File: rtl/agc_lane.sv
// One lane: sample register, fine multiply plus coarse shift, 19-bit
// saturation, then clipping to the selected width with residue.
module agc_lane
    import agc_gain_pkg::*;
#(
    parameter int IN_W     = AGC_IN_W,
    parameter int EXP_W    = AGC_EXP_W,
    parameter int FRAC_W   = AGC_LUT_FRAC,
    parameter int SCALED_W = AGC_SCALED_W,
    parameter int OUT_W    = AGC_OUT_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic signed [IN_W-1:0]     in_x,
    input  logic                       s1_valid,
    input  logic [FRAC_W:0]            s1_mult,
    input  logic [EXP_W-1:0]           s1_exp,
    input  logic                       s2_valid,
    input  wsel_t                      s2_wsel,
    output logic signed [SCALED_W-1:0] scaled,
    output logic signed [OUT_W-1:0]    req,
    output logic signed [SCALED_W-1:0] err
);

    localparam int LUT_W   = FRAC_W + 1;
    localparam int PROD_W  = IN_W + LUT_W + 1;
    localparam int SHIFT_W = PROD_W + (1 << EXP_W) - 1;

    localparam logic signed [SHIFT_W-1:0] SC_HI =
        {{(SHIFT_W - SCALED_W + 1){1'b0}}, {(SCALED_W - 1){1'b1}}};
    localparam logic signed [SHIFT_W-1:0] SC_LO =
        {{(SHIFT_W - SCALED_W + 1){1'b1}}, {(SCALED_W - 1){1'b0}}};

    typedef struct packed {
        logic [IN_W-1:0]     x1;
        logic [SCALED_W-1:0] sc2;
        logic [SCALED_W-1:0] sc3;
        logic [OUT_W-1:0]    rq3;
        logic [SCALED_W-1:0] er3;
    } lane_st_t;

    lane_st_t st_q, st_d;

    logic signed [PROD_W-1:0]   prod;
    logic signed [SHIFT_W-1:0]  shifted;
    logic signed [SCALED_W-1:0] sat_val;
    logic signed [SCALED_W-1:0] lim_hi;
    logic signed [SCALED_W-1:0] lim_lo;
    logic signed [SCALED_W-1:0] clip;

    always_comb begin
        st_d = st_q;

        // stage 2: fine multiply, coarse shift, drop fraction, saturate
        prod    = PROD_W'($signed(st_q.x1)) * PROD_W'($signed({1'b0, s1_mult}));
        shifted = SHIFT_W'(prod) <<< s1_exp;
        shifted = shifted >>> FRAC_W;
        if (shifted > SC_HI)      sat_val = SC_HI[SCALED_W-1:0];
        else if (shifted < SC_LO) sat_val = SC_LO[SCALED_W-1:0];
        else                      sat_val = shifted[SCALED_W-1:0];

        // stage 3: clip to the selected width, keep the residue
        lim_hi = SCALED_W'((1 << (width_of(s2_wsel) - 1)) - 1);
        lim_lo = ~lim_hi;
        if ($signed(st_q.sc2) > lim_hi)      clip = lim_hi;
        else if ($signed(st_q.sc2) < lim_lo) clip = lim_lo;
        else                                 clip = $signed(st_q.sc2);

        if (in_valid) st_d.x1 = in_x;
        if (s1_valid) st_d.sc2 = sat_val;
        if (s2_valid) begin
            st_d.sc3 = st_q.sc2;
            st_d.rq3 = OUT_W'(clip);
            st_d.er3 = $signed(st_q.sc2) - clip;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign scaled = $signed(st_q.sc3);
    assign req    = $signed(st_q.rq3);
    assign err    = $signed(st_q.er3);

endmodule

// File: rtl/agc_gain_requant.sv
module agc_gain_requant
    import agc_gain_pkg::*;
#(
    parameter int IN_W     = AGC_IN_W,
    parameter int EXP_W    = AGC_EXP_W,
    parameter int MANT_W   = AGC_MANT_W,
    parameter int FRAC_W   = AGC_LUT_FRAC,
    parameter int SCALED_W = AGC_SCALED_W,
    parameter int OUT_W    = AGC_OUT_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic signed [IN_W-1:0]     in_i,
    input  logic signed [IN_W-1:0]     in_q,
    input  logic                       gain_load,
    input  logic [EXP_W+MANT_W-1:0]    gain_word,
    input  logic [EXP_W+MANT_W-1:0]    init_gain,
    input  logic [2:0]                 width_sel,
    output logic                       out_valid,
    output logic signed [SCALED_W-1:0] scaled_i,
    output logic signed [SCALED_W-1:0] scaled_q,
    output logic signed [OUT_W-1:0]    req_i,
    output logic signed [OUT_W-1:0]    req_q,
    output logic signed [SCALED_W-1:0] err_i,
    output logic signed [SCALED_W-1:0] err_q
);

    localparam int GAIN_W = EXP_W + MANT_W;
    localparam int LUT_W  = FRAC_W + 1;
    localparam int LANES  = 2;

    typedef struct packed {
        logic             v1;
        logic             v2;
        logic             v3;
        logic [LUT_W-1:0] mult1;
        logic [EXP_W-1:0] exp1;
        wsel_t            wsel1;
        wsel_t            wsel2;
    } top_st_t;

    top_st_t st_q, st_d;

    logic [GAIN_W-1:0] eff_gain;
    logic [LUT_W-1:0]  lut_mult;

    agc_gain_select #(.GAIN_W(GAIN_W)) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (gain_load),
        .word      (gain_word),
        .init_word (init_gain),
        .active    (eff_gain)
    );

    agc_mant_lut #(.MANT_W(MANT_W), .FRAC_W(FRAC_W)) u_lut (
        .mant (eff_gain[MANT_W-1:0]),
        .mult (lut_mult)
    );

    // stage 1: one gain snapshot per sample, shared by both lanes
    always_comb begin
        st_d    = st_q;
        st_d.v1 = in_valid;
        st_d.v2 = st_q.v1;
        st_d.v3 = st_q.v2;
        if (in_valid) begin
            st_d.mult1 = lut_mult;
            st_d.exp1  = eff_gain[GAIN_W-1 -: EXP_W];
            st_d.wsel1 = width_sel;
        end
        if (st_q.v1) st_d.wsel2 = st_q.wsel1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    logic signed [IN_W-1:0]     lane_in     [LANES];
    logic signed [SCALED_W-1:0] lane_scaled [LANES];
    logic signed [OUT_W-1:0]    lane_req    [LANES];
    logic signed [SCALED_W-1:0] lane_err    [LANES];

    assign lane_in[0] = in_i;
    assign lane_in[1] = in_q;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        agc_lane #(
            .IN_W     (IN_W),
            .EXP_W    (EXP_W),
            .FRAC_W   (FRAC_W),
            .SCALED_W (SCALED_W),
            .OUT_W    (OUT_W)
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_valid (in_valid),
            .in_x     (lane_in[l]),
            .s1_valid (st_q.v1),
            .s1_mult  (st_q.mult1),
            .s1_exp   (st_q.exp1),
            .s2_valid (st_q.v2),
            .s2_wsel  (st_q.wsel2),
            .scaled   (lane_scaled[l]),
            .req      (lane_req[l]),
            .err      (lane_err[l])
        );
    end

    assign out_valid = st_q.v3;
    assign scaled_i  = lane_scaled[0];
    assign scaled_q  = lane_scaled[1];
    assign req_i     = lane_req[0];
    assign req_q     = lane_req[1];
    assign err_i     = lane_err[0];
    assign err_q     = lane_err[1];

endmodule

// File: rtl/agc_gain_requant_chk.sv
module agc_gain_requant_chk
    import agc_gain_pkg::*;
#(
    parameter int GAIN_W   = 12,
    parameter int SCALED_W = 19,
    parameter int OUT_W    = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       in_valid,
    input logic [2:0]                 width_sel,
    input logic                       gain_load,
    input logic [GAIN_W-1:0]          gain_word,
    input logic [GAIN_W-1:0]          act_gain,
    input logic                       out_valid,
    input logic signed [SCALED_W-1:0] scaled_i,
    input logic signed [SCALED_W-1:0] scaled_q,
    input logic signed [OUT_W-1:0]    req_i,
    input logic signed [OUT_W-1:0]    req_q,
    input logic signed [SCALED_W-1:0] err_i,
    input logic signed [SCALED_W-1:0] err_q
);

    logic [2:0] vp;
    wsel_t      ws1, ws2, ws3;
    logic signed [OUT_W-1:0] hi, lo;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vp  <= '0;
            ws1 <= '0;
            ws2 <= '0;
            ws3 <= '0;
        end else begin
            vp <= {vp[1:0], in_valid};
            if (in_valid) ws1 <= width_sel;
            if (vp[0])    ws2 <= ws1;
            if (vp[1])    ws3 <= ws2;
        end
    end

    always_comb begin
        hi = OUT_W'((1 << (width_of(ws3) - 1)) - 1);
        lo = ~hi;
    end

    assert_valid_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vp[2]);

    assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(req_i) && $stable(req_q) && $stable(scaled_i)
                        && $stable(scaled_q) && $stable(err_i) && $stable(err_q)));

    assert_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (req_i <= hi && req_i >= lo && req_q <= hi && req_q >= lo));

    assert_clip_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (err_i > 0 || err_q > 0)) |->
            ((err_i <= 0 || req_i == hi) && (err_q <= 0 || req_q == hi)));

    assert_clip_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (err_i < 0 || err_q < 0)) |->
            ((err_i >= 0 || req_i == lo) && (err_q >= 0 || req_q == lo)));

    assert_no_residue_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && req_i != hi && req_i != lo) |-> err_i == 0);

    assert_gain_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
        gain_load |=> act_gain == $past(gain_word));

endmodule

bind agc_gain_requant agc_gain_requant_chk #(
    .GAIN_W   (GAIN_W),
    .SCALED_W (SCALED_W),
    .OUT_W    (OUT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .width_sel (width_sel),
    .gain_load (gain_load),
    .gain_word (gain_word),
    .act_gain  (eff_gain),
    .out_valid (out_valid),
    .scaled_i  (scaled_i),
    .scaled_q  (scaled_q),
    .req_i     (req_i),
    .req_q     (req_q),
    .err_i     (err_i),
    .err_q     (err_q)
);

// File: tb/tb_agc_gain_requant.sv
module tb_agc_gain_requant;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_i = '0;
    logic signed [15:0] in_q = '0;
    logic               gain_load = 1'b0;
    logic [11:0]        gain_word = '0;
    logic [11:0]        init_gain = '0;
    logic [2:0]         width_sel = '0;
    logic               out_valid;
    logic signed [18:0] scaled_i, scaled_q, err_i, err_q;
    logic signed [15:0] req_i, req_q;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    agc_gain_requant dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .gain_load(gain_load), .gain_word(gain_word), .init_gain(init_gain),
        .width_sel(width_sel), .out_valid(out_valid), .scaled_i(scaled_i),
        .scaled_q(scaled_q), .req_i(req_i), .req_q(req_q), .err_i(err_i), .err_q(err_q)
    );

    // stimulus: {x_i, x_q, gain word, width code}
    localparam int NV = 13;
    localparam logic [46:0] VEC [NV] = '{
        {16'sd1000,   -16'sd1000,  12'h000, 3'd7},
        {16'sd1000,   -16'sd1000,  12'h080, 3'd7},
        {16'sd300,    16'sd77,     12'h1FF, 3'd7},
        {-16'sd1,     16'sd1,      12'h000, 3'd0},
        {16'sd100,    -16'sd100,   12'h000, 3'd0},
        {16'sd20000,  -16'sd20000, 12'h3C0, 3'd7},
        {16'sd32767,  -16'sd32768, 12'hFFF, 3'd6},
        {16'sd1234,   -16'sd567,   12'h2A5, 3'd5},
        {16'sd500,    16'sd600,    12'h140, 3'd4},
        {-16'sd3,     16'sd5,      12'h7FF, 3'd3},
        {16'sd29,     -16'sd31,    12'h010, 3'd2},
        {16'sd0,      16'sd0,      12'h5AA, 3'd1},
        {-16'sd12345, 16'sd12345,  12'h033, 3'd6}
    };

    function automatic longint lut_ref(input int m);
        return longint'($rtoi((2.0 ** (real'(m) / 256.0)) * 1024.0 + 0.5));
    endfunction

    function automatic longint sat_ref(input longint v, input int w);
        longint hi = (longint'(1) <<< (w - 1)) - 1;
        longint lo = -hi - 1;
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    function automatic int width_ref(input logic [2:0] c);
        case (c)
            3'd0: return 4;   3'd1: return 5;   3'd2: return 6;   3'd3: return 7;
            3'd4: return 8;   3'd5: return 10;  3'd6: return 12;  default: return 16;
        endcase
    endfunction

    function automatic longint scaled_ref(input logic signed [15:0] x, input logic [11:0] g);
        longint p = longint'(x) * lut_ref(int'(g[7:0]));
        p = p <<< int'(g[11:8]);
        p = p >>> 10;
        return sat_ref(p, 19);
    endfunction

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic compare_out(input logic signed [15:0] xi, input logic signed [15:0] xq,
                               input logic [2:0] ws, input logic [11:0] g, input string tag);
        longint si = scaled_ref(xi, g);
        longint sq = scaled_ref(xq, g);
        longint ri = sat_ref(si, width_ref(ws));
        longint rq = sat_ref(sq, width_ref(ws));
        check({tag, " R1 scaled_i"}, longint'(scaled_i), si);
        check({tag, " R1 scaled_q"}, longint'(scaled_q), sq);
        check({tag, " R6 R7 req_i"}, longint'(req_i), ri);
        check({tag, " R6 R7 req_q"}, longint'(req_q), rq);
        check({tag, " R8 err_i"}, longint'(err_i), si - ri);
        check({tag, " R8 err_q"}, longint'(err_q), sq - rq);
    endtask

    task automatic load_gain(input logic [11:0] g);
        @(negedge clk);
        gain_word = g;
        gain_load = 1'b1;
        @(negedge clk);
        gain_load = 1'b0;
    endtask

    task automatic sample_check(input logic signed [15:0] xi, input logic signed [15:0] xq,
                                input logic [2:0] ws, input logic [11:0] g, input string tag);
        @(negedge clk);
        in_i = xi; in_q = xq; width_sel = ws; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check({tag, " R9 valid low before third edge"}, longint'(out_valid), 0);
        @(negedge clk);
        check({tag, " R9 valid on third edge"}, longint'(out_valid), 1);
        compare_out(xi, xq, ws, g, tag);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [11:0] g_last;
        init_gain = 12'h100;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 reset out_valid", longint'(out_valid), 0);
        check("R10 reset scaled_i", longint'(scaled_i), 0);
        check("R10 reset req_q", longint'(req_q), 0);
        check("R10 reset err_i", longint'(err_i), 0);

        // R4 startup gain before any load (x2)
        sample_check(16'sd1000, -16'sd700, 3'd7, 12'h100, "R4 init");
        check("R4 init doubles", longint'(scaled_i), 2000);

        // table walk
        for (int k = 0; k < NV; k++) begin
            load_gain(VEC[k][14:3]);
            sample_check(VEC[k][46:31], VEC[k][30:15], VEC[k][2:0], VEC[k][14:3], "vector");
        end

        // R2 literal table values
        load_gain(12'h000);
        sample_check(16'sd1000, -16'sd1000, 3'd7, 12'h000, "R2 unity");
        check("R2 unity literal", longint'(scaled_i), 1000);
        load_gain(12'h080);
        sample_check(16'sd1000, -16'sd1000, 3'd7, 12'h080, "R2 half-octave");
        check("R2 1448 literal", longint'(scaled_i), 1414);

        // R3 saturation at the full-scale gain
        load_gain(12'hFFF);
        sample_check(16'sd32767, -16'sd32768, 3'd6, 12'hFFF, "R3 full");
        check("R3 positive limit", longint'(scaled_i), 262143);
        check("R3 negative limit", longint'(scaled_q), -262144);
        g_last = 12'hFFF;

        // R5 strobe in the same cycle as a sample: old gain applies
        @(negedge clk);
        gain_word = 12'h100; gain_load = 1'b1;
        in_i = 16'sd100; in_q = -16'sd50; width_sel = 3'd7; in_valid = 1'b1;
        @(negedge clk);
        gain_load = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        compare_out(16'sd100, -16'sd50, 3'd7, g_last, "R5 same cycle");
        sample_check(16'sd1000, -16'sd500, 3'd7, 12'h100, "R5 next sample");
        check("R5 both lanes one gain", longint'(scaled_q), -1000);

        // R4 startup value ignored after a load
        init_gain = 12'hF00;
        sample_check(16'sd1000, -16'sd500, 3'd7, 12'h100, "R4 after load");

        // R11 back-to-back samples with changing widths
        @(negedge clk);
        in_i = 16'sd5000;  in_q = -16'sd5000;  width_sel = 3'd0; in_valid = 1'b1;
        @(negedge clk);
        in_i = 16'sd50;    in_q = -16'sd50;    width_sel = 3'd3;
        @(negedge clk);
        in_i = 16'sd30000; in_q = -16'sd30000; width_sel = 3'd7;
        @(negedge clk);
        in_valid = 1'b0;
        check("R11 first valid", longint'(out_valid), 1);
        compare_out(16'sd5000, -16'sd5000, 3'd0, 12'h100, "R11 first");
        @(negedge clk);
        compare_out(16'sd50, -16'sd50, 3'd3, 12'h100, "R11 second");
        @(negedge clk);
        compare_out(16'sd30000, -16'sd30000, 3'd7, 12'h100, "R11 third");

        // R10 outputs hold while idle
        repeat (4) @(negedge clk);
        check("R10 idle valid", longint'(out_valid), 0);
        check("R10 hold scaled_i", longint'(scaled_i), 60000);
        check("R10 hold req_i", longint'(req_i), 32767);
        check("R10 hold err_q", longint'(err_q), -60000 + 32768);

        finish_run();
    end

endmodule